// File: doc/BRIEF.md
# DMA Channel with Memory-Error Recovery

This block runs one descriptor-driven DMA channel that reads words from memory and pushes them onto a simple bus-master data port. Software writes a descriptor pointer and sets the enable bit. The channel looks up the descriptor, which holds a source address, a word count and a link to the next descriptor. It issues ascending memory reads, stages the returned words in a small buffer, and drives them onto the bus in order. When a descriptor completes, the pointer follows the link. A null link ends the chain and turns the channel off.

A word reaches the buffer only after its memory response has arrived clean. When a response comes back flagged as bad, the bus transfer is cut short before that word can be driven. Any words still waiting in the buffer are thrown away, and an abort strobe is raised. The channel then turns itself off and raises its error bit and a sticky status flag, which can drive an interrupt. It also ignores any responses still in flight, and drops back to idle. The pointer is left on the failed descriptor. Software clears the error bit and enables the channel again to retry that descriptor from its first word.

Top module: `dmaErrChan`

## Requirements
- R1: After reset, the channel register (offset 0), the pointer register (offset 1) and the status register (offset 2) all read zero, and busValid, memReqValid, busAbort and irq are low.
- R2: For each descriptor, reads go to the source address, then that address plus 4 for each further word. Bus words leave in request order and carry the memory data, and busLast marks the final word of each descriptor. On completion the pointer takes the link value. A zero link clears the enable bit. A zero-length descriptor sends nothing and still advances.
- R3: Memory requests still waiting for a response, plus words held in the buffer, never exceed 4.
- R4: The word whose response carries the error flag never appears on the bus, and neither does any later word of the transfer. busValid and memReqValid are low from the cycle after that response, and busAbort is high for exactly that one cycle.
- R5: A memory error clears the enable bit (channel register bit 0), sets the error bit (bit 1), and sets the sticky error flag (status register bit 0).
- R6: After a memory error the pointer register still holds the address of the failed descriptor.
- R7: Responses still outstanding at the error are discarded, and no request is issued until software restarts the channel. A restart begins at the first word of the pointed-to descriptor, with an empty buffer.
- R8: Channel register bit 0 is enable (writing 0 clears it) and bit 1 is error (writing 1 clears it). Writing 1 to bit 0 while the error bit is set has no effect.
- R9: Status register bit 0 is the sticky error flag (writing 1 clears it) and bit 1 is the interrupt enable (read/write). irq equals bit 0 AND bit 1.
- R10: A write to the pointer register is taken only while the enable bit is 0 and is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset for reads and writes |
| regWrData | input | ADDR_W | Register write data |
| regRdData | output | ADDR_W | Register read data for regAddr (combinational) |
| descAddr | output | ADDR_W | Current descriptor pointer, used to look up the descriptor |
| descSrc | input | ADDR_W | Source address of the descriptor at descAddr |
| descLen | input | LEN_W | Word count of the descriptor at descAddr |
| descNext | input | ADDR_W | Link of the descriptor at descAddr (zero ends the chain) |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Memory read byte address |
| memRspValid | input | 1 | Memory response valid (in request order) |
| memRspData | input | DATA_W | Memory response data |
| memRspErr | input | 1 | Memory response carries an error |
| busValid | output | 1 | Bus data word valid |
| busReady | input | 1 | Bus accepts the word |
| busData | output | DATA_W | Bus data word |
| busLast | output | 1 | Word is the final one of its descriptor |
| busAbort | output | 1 | One-cycle strobe: transfer terminated by a memory error |
| irq | output | 1 | Interrupt: sticky error flag with interrupt enabled |

## Verification
A control state that stays active after an error shows up at once, as busValid or memReqValid high in the very next cycle, or as a missing busAbort strobe. A buffer that is not emptied shows up at the first word after a restart, because a stale word appears in place of the descriptor's first word. A wrong outstanding count shows up either as requests that run past the four-entry bound, or as a drain that never ends, so the enable-and-error readback does not settle. A pointer that moves on error, or takes a write while enabled, is visible at the next read of offset 1.

// File: rtl/dma_err_pkg.sv
`timescale 1ns/1ps
package dma_err_pkg;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ACTIVE = 2'd1,
    CH_DRAIN  = 2'd2
  } chState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic active;
    logic done;
    logic errHit;
  } ctlStrobes_t;

  // conditions from datapath to control
  typedef struct packed {
    logic chanGo;
    logic xferDone;
    logic rspErr;
    logic outZero;
  } dpStatus_t;

  localparam logic [1:0] REG_CHAN = 2'd0;
  localparam logic [1:0] REG_DESC = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

endpackage

// File: rtl/dmaErrFifo.sv
`timescale 1ns/1ps
module dmaErrFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign rdData = store[rdPtr];
  assign empty  = (count == '0);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && wrPtr == PTR_W'(gi)) store[gi] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      unique case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dmaErrCtrl.sv
`timescale 1ns/1ps
module dmaErrCtrl
  import dma_err_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   st,
  output ctlStrobes_t ctl,
  output logic        busAbort
);
  chState_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      CH_IDLE: begin
        if (st.chanGo) begin
          ctl.start = 1'b1;
          stateNext = CH_ACTIVE;
        end
      end
      CH_ACTIVE: begin
        ctl.active = 1'b1;
        if (st.rspErr) begin
          ctl.errHit = 1'b1;
          stateNext  = CH_DRAIN;
        end else if (st.xferDone) begin
          ctl.done  = 1'b1;
          stateNext = CH_IDLE;
        end
      end
      CH_DRAIN: begin
        if (st.outZero) stateNext = CH_IDLE;
      end
      default: stateNext = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= CH_IDLE;
      busAbort <= 1'b0;
    end else begin
      state    <= stateNext;
      busAbort <= ctl.errHit;
    end
  end
endmodule

// File: rtl/dmaErrDatapath.sv
`timescale 1ns/1ps
module dmaErrDatapath
  import dma_err_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  output dpStatus_t         st,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic [ADDR_W-1:0] descAddr,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [ADDR_W-1:0] descNext,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              busValid,
  input  logic              busReady,
  output logic [DATA_W-1:0] busData,
  output logic              busLast,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [ADDR_W-1:0] ADDR_STEP  = ADDR_W'(DATA_W / 8);
  localparam logic [SUM_W-1:0]  CREDIT_MAX = SUM_W'(FIFO_DEPTH);
  localparam logic [LEN_W-1:0]  LEN_ONE    = LEN_W'(1);

  logic              chEn, chErr, memErrFlag, irqEn;
  logic [ADDR_W-1:0] descPtr, curNext, curAddr;
  logic [LEN_W-1:0]  curLen, issuedCnt, sentCnt;
  logic [CNT_W-1:0]  outCnt, bufCnt;
  logic [SUM_W-1:0]  inFlight;
  logic              fifoEmpty, reqFire, busFire, pushRsp;
  logic              wrChan, wrDesc, wrStat;

  assign wrChan = regWrEn && (regAddr == REG_CHAN);
  assign wrDesc = regWrEn && (regAddr == REG_DESC);
  assign wrStat = regWrEn && (regAddr == REG_STAT);

  assign inFlight    = SUM_W'(outCnt) + SUM_W'(bufCnt);
  assign memReqValid = ctl.active && (issuedCnt != curLen) && (inFlight < CREDIT_MAX);
  assign memReqAddr  = curAddr;
  assign reqFire     = memReqValid && memReqReady;

  assign busValid = ctl.active && !fifoEmpty;
  assign busLast  = busValid && (sentCnt == curLen - LEN_ONE);
  assign busFire  = busValid && busReady;
  assign pushRsp  = ctl.active && memRspValid && !memRspErr;

  assign descAddr = descPtr;
  assign irq      = memErrFlag && irqEn;

  assign st.chanGo   = chEn && !chErr;
  assign st.xferDone = (sentCnt == curLen) && (outCnt == '0);
  assign st.rspErr   = memRspValid && memRspErr;
  assign st.outZero  = (outCnt == '0);

  dmaErrFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (ctl.errHit),
    .push   (pushRsp),
    .pop    (busFire),
    .wrData (memRspData),
    .rdData (busData),
    .empty  (fifoEmpty)
  );

  // buffer occupancy, shadowed here for the request credit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufCnt <= '0;
    else if (ctl.errHit) bufCnt <= '0;
    else begin
      unique case ({pushRsp, busFire})
        2'b10:   bufCnt <= bufCnt + CNT_W'(1);
        2'b01:   bufCnt <= bufCnt - CNT_W'(1);
        default: bufCnt <= bufCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outCnt <= '0;
    else begin
      unique case ({reqFire, memRspValid})
        2'b10:   outCnt <= outCnt + CNT_W'(1);
        2'b01:   outCnt <= outCnt - CNT_W'(1);
        default: outCnt <= outCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curLen    <= '0;
      issuedCnt <= '0;
      sentCnt   <= '0;
    end else if (ctl.start) begin
      curAddr   <= descSrc;
      curLen    <= descLen;
      issuedCnt <= '0;
      sentCnt   <= '0;
    end else if (ctl.errHit) begin
      curLen    <= '0;
      issuedCnt <= '0;
      sentCnt   <= '0;
    end else begin
      if (reqFire) begin
        curAddr   <= curAddr + ADDR_STEP;
        issuedCnt <= issuedCnt + LEN_ONE;
      end
      if (busFire) sentCnt <= sentCnt + LEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chEn       <= 1'b0;
      chErr      <= 1'b0;
      memErrFlag <= 1'b0;
      irqEn      <= 1'b0;
      descPtr    <= '0;
      curNext    <= '0;
    end else begin
      if (ctl.errHit)                        chEn <= 1'b0;
      else if (ctl.done && curNext == '0)    chEn <= 1'b0;
      else if (wrChan) begin
        if (!regWrData[0])                   chEn <= 1'b0;
        else if (!chErr)                     chEn <= 1'b1;
      end

      if (ctl.errHit)                        chErr <= 1'b1;
      else if (wrChan && regWrData[1])       chErr <= 1'b0;

      if (ctl.done)                          descPtr <= curNext;
      else if (wrDesc && !chEn)              descPtr <= regWrData;

      if (ctl.start)                         curNext <= descNext;

      if (ctl.errHit)                        memErrFlag <= 1'b1;
      else if (wrStat && regWrData[0])       memErrFlag <= 1'b0;

      if (wrStat)                            irqEn <= regWrData[1];
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CHAN: regRdData = ADDR_W'({chErr, chEn});
      REG_DESC: regRdData = descPtr;
      REG_STAT: regRdData = ADDR_W'({irqEn, memErrFlag});
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dmaErrChan.sv
`timescale 1ns/1ps
module dmaErrChan
  import dma_err_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic [ADDR_W-1:0] descAddr,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [ADDR_W-1:0] descNext,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              busValid,
  input  logic              busReady,
  output logic [DATA_W-1:0] busData,
  output logic              busLast,
  output logic              busAbort,
  output logic              irq
);
  ctlStrobes_t ctl;
  dpStatus_t   st;

  dmaErrCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .ctl      (ctl),
    .busAbort (busAbort)
  );

  dmaErrDatapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .st          (st),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .descAddr    (descAddr),
    .descSrc     (descSrc),
    .descLen     (descLen),
    .descNext    (descNext),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memReqAddr  (memReqAddr),
    .memRspValid (memRspValid),
    .memRspData  (memRspData),
    .memRspErr   (memRspErr),
    .busValid    (busValid),
    .busReady    (busReady),
    .busData     (busData),
    .busLast     (busLast),
    .irq         (irq)
  );
endmodule

// File: rtl/dmaErrChan_chk.sv
`timescale 1ns/1ps
module dmaErrChan_chk
  import dma_err_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input logic        clk,
  input logic        rstN,
  input ctlStrobes_t ctl,
  input logic        busValid,
  input logic        busLast,
  input logic        busAbort,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic        memRspValid,
  input logic [1:0]  regAddr,
  input logic [1:0]  regRdLow,
  input logic        irq
);
  logic [7:0] trackOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trackOut <= '0;
    else begin
      unique case ({memReqValid && memReqReady, memRspValid})
        2'b10:   trackOut <= trackOut + 8'd1;
        2'b01:   trackOut <= trackOut - 8'd1;
        default: trackOut <= trackOut;
      endcase
    end
  end

  p_inflight_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    trackOut <= 8'(FIFO_DEPTH));

  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.errHit |=> (!busValid && !memReqValid));

  p_abort_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    busAbort |-> (!busValid && !memReqValid));

  p_bus_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ctl.active);

  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    busLast |-> busValid);

  p_no_req_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> !memReqValid);

  p_err_excl_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_CHAN) |-> !(regRdLow[0] && regRdLow[1]));

  p_irq_mirror_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_STAT) |-> (irq == (regRdLow[0] && regRdLow[1])));
endmodule

bind dmaErrChan dmaErrChan_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctl         (ctl),
  .busValid    (busValid),
  .busLast     (busLast),
  .busAbort    (busAbort),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memRspValid (memRspValid),
  .regAddr     (regAddr),
  .regRdLow    (regRdData[1:0]),
  .irq         (irq)
);

// File: tb/dmaErrChan_tb_top.sv
`timescale 1ns/1ps
module dmaErrChan_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] descAddr, descSrc, descNext;
  logic [15:0] descLen;
  logic        memReqValid, memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;
  logic        busValid, busReady = 1'b0, busLast, busAbort, irq;
  logic [31:0] busData;

  always #2.5 clk = ~clk;

  dmaErrChan dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .descAddr(descAddr),
    .descSrc(descSrc), .descLen(descLen), .descNext(descNext),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .busValid(busValid), .busReady(busReady), .busData(busData),
    .busLast(busLast), .busAbort(busAbort), .irq(irq)
  );

  // descriptor table seen by the channel
  always_comb begin
    descSrc = '0; descLen = '0; descNext = '0;
    case (descAddr)
      32'h100: begin descSrc = 32'h1000; descLen = 16'd6; descNext = 32'h110; end
      32'h110: begin descSrc = 32'h2000; descLen = 16'd0; descNext = 32'h120; end
      32'h120: begin descSrc = 32'h3000; descLen = 16'd3; descNext = 32'h0;   end
      32'h130: begin descSrc = 32'h4000; descLen = 16'd8; descNext = 32'h0;   end
      default: ;
    endcase
  end

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int bufCount = 0;
  bit errFlag = 0;
  bit abortExp = 0;
  bit errArmed = 0;
  logic [31:0] errAddr = '0;
  logic [31:0] pendQ[$];
  logic [31:0] reqExpQ[$];
  logic [31:0] busExpQ[$];
  bit          lastExpQ[$];

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // reference expectations for a chain starting at p
  task automatic buildExp(input logic [31:0] p);
    logic [31:0] s, n;
    int len;
    reqExpQ.delete(); busExpQ.delete(); lastExpQ.delete();
    for (int k = 0; k < 8 && p != 0; k++) begin
      case (p)
        32'h100: begin s = 32'h1000; len = 6; n = 32'h110; end
        32'h110: begin s = 32'h2000; len = 0; n = 32'h120; end
        32'h120: begin s = 32'h3000; len = 3; n = 32'h0;   end
        32'h130: begin s = 32'h4000; len = 8; n = 32'h0;   end
        default: begin s = 32'h0;    len = 0; n = 32'h0;   end
      endcase
      for (int i = 0; i < len; i++) begin
        reqExpQ.push_back(s + 32'(4 * i));
        busExpQ.push_back(s + 32'(4 * i));
        lastExpQ.push_back(i == len - 1);
      end
      p = n;
    end
    errFlag = 0;
  endtask

  // one clock of the memory and bus model, compared against the reference
  task automatic step();
    logic [31:0] a, e;
    bit rspNow, errNow, eLast;
    @(negedge clk);
    regWrEn = 1'b0;
    cyc++;
    rspNow = 0; errNow = 0;
    if (pendQ.size() > 0 && (cyc % 3) != 1) begin
      a = pendQ.pop_front();
      errNow = errArmed && (a == errAddr);
      if (errNow) errArmed = 0;
      memRspValid = 1'b1; memRspData = memWord(a); memRspErr = errNow;
      rspNow = 1;
    end else begin
      memRspValid = 1'b0; memRspData = '0; memRspErr = 1'b0;
    end
    busReady    = (cyc % 4) != 3;
    memReqReady = (cyc % 5) != 2;
    #1;
    check(busAbort == abortExp, "R4 abort strobe", 32'(busAbort), 32'(abortExp));
    if (errFlag) begin
      check(!busValid, "R4 bus quiet after error", 32'(busValid), 0);
      check(!memReqValid, "R7 no request after error", 32'(memReqValid), 0);
    end
    if (busValid && busReady) begin
      if (busExpQ.size() == 0) check(0, "R2 unexpected bus word", busData, 0);
      else begin
        e = busExpQ.pop_front(); eLast = lastExpQ.pop_front();
        check(busData == memWord(e), "R2 bus data", busData, memWord(e));
        check(busLast == eLast, "R2 busLast", 32'(busLast), 32'(eLast));
      end
      bufCount--;
    end
    if (memReqValid && memReqReady) begin
      if (reqExpQ.size() == 0) check(0, "R2 unexpected request", memReqAddr, 0);
      else begin
        e = reqExpQ.pop_front();
        check(memReqAddr == e, "R2 request address", memReqAddr, e);
      end
      pendQ.push_back(memReqAddr);
    end
    if (rspNow && !errFlag && !errNow) bufCount++;
    check(pendQ.size() + bufCount <= 4, "R3 in-flight bound", 32'(pendQ.size() + bufCount), 4);
    abortExp = errNow;
    if (errNow) begin
      errFlag = 1;
      reqExpQ.delete(); busExpQ.delete(); lastExpQ.delete();
      bufCount = 0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    step();
    v = regRdData;
  endtask

  task automatic runIdle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, v);
      if (v[0] == 1'b0 && pendQ.size() == 0) break;
    end
    repeat (3) step();
  endtask

  initial begin
    #1000000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    check(!busValid && !memReqValid, "R1 outputs idle in reset", {busValid, memReqValid}, 0);
    check(!busAbort && !irq, "R1 abort/irq low in reset", {busAbort, irq}, 0);
    rstN = 1'b1;
    rd(2'd0, v); check(v == 0, "R1 channel reg", v, 0);
    rd(2'd1, v); check(v == 0, "R1 pointer reg", v, 0);
    rd(2'd2, v); check(v == 0, "R1 status reg", v, 0);

    // normal chain with a zero-length descriptor in the middle
    wr(2'd2, 32'h2);
    wr(2'd1, 32'h100);
    rd(2'd1, v); check(v == 32'h100, "R10 pointer write while disabled", v, 32'h100);
    buildExp(32'h100);
    wr(2'd0, 32'h1);
    runIdle();
    rd(2'd0, v); check(v == 0, "R2 chain end clears enable", v, 0);
    rd(2'd1, v); check(v == 0, "R2 pointer follows links", v, 0);
    check(busExpQ.size() == 0, "R2 all words delivered", 32'(busExpQ.size()), 0);
    check(!irq, "R9 no irq without error", 32'(irq), 0);

    // error on the sixth word with several requests in flight
    wr(2'd1, 32'h130);
    buildExp(32'h130);
    errAddr = 32'h4014; errArmed = 1;
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h240);
    runIdle();
    rd(2'd0, v); check(v == 32'h2, "R5 enable cleared, error set", v, 32'h2);
    rd(2'd2, v); check(v == 32'h3, "R5 sticky flag set", v, 32'h3);
    check(irq, "R9 irq raised", 32'(irq), 1);
    rd(2'd1, v); check(v == 32'h130, "R6 R10 pointer kept", v, 32'h130);

    wr(2'd0, 32'h1);
    rd(2'd0, v); check(v == 32'h2, "R8 enable blocked by error", v, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, v); check(v == 32'h3, "R9 write 0 keeps flag", v, 32'h3);
    wr(2'd2, 32'h3);
    rd(2'd2, v); check(v == 32'h2, "R9 write 1 clears flag", v, 32'h2);
    check(!irq, "R9 irq drops", 32'(irq), 0);
    wr(2'd0, 32'h2);
    rd(2'd0, v); check(v == 0, "R8 error cleared", v, 0);

    // restart retries the failed descriptor from its first word
    buildExp(32'h130);
    wr(2'd0, 32'h1);
    runIdle();
    rd(2'd0, v); check(v == 0, "R7 restart completes", v, 0);
    check(busExpQ.size() == 0, "R7 retried words delivered", 32'(busExpQ.size()), 0);

    // error on the very first word, interrupt disabled
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h100);
    buildExp(32'h100);
    errAddr = 32'h1000; errArmed = 1;
    wr(2'd0, 32'h1);
    runIdle();
    rd(2'd2, v); check(v == 32'h1, "R9 flag set, irq masked", v, 32'h1);
    check(!irq, "R9 irq masked", 32'(irq), 0);
    rd(2'd1, v); check(v == 32'h100, "R6 pointer on failed descriptor", v, 32'h100);
    rd(2'd0, v); check(v == 32'h2, "R5 error state", v, 32'h2);
    wr(2'd2, 32'h2);
    check(irq, "R9 irq after enabling", 32'(irq), 1);

    finishRun();
  end
endmodule